// File: doc/BRIEF.md
# Call, Return and Frame Stack Sequencer

This block carries out the stack traffic of subroutine linkage for a 16-bit processor core. It is given one command with its operands: the address of the next instruction, the current code segment, a general argument and a target segment. It then makes the word-sized memory accesses that the command needs, one after another. Each access waits for the memory to answer. The block owns the stack pointer and the frame base pointer. When the sequence finishes it presents the instruction pointer and code segment at which execution continues.

The command set has seven entries. There are three call forms: relative, absolute far, and through a register value. There are two return forms, near and far, and each can also drop a number of argument bytes. The last two commands build and tear down a base-pointer frame. The stack grows toward lower addresses. A push first lowers the stack pointer by one word and then writes. A pop reads first and then raises the stack pointer by one word. A core issues a command when `busy` is low and takes the results in the cycle where `done` is high.

Top module: `callret_seq`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are low, `sp_out` equals SP_INIT (0x0100), and `bp_out`, `ip_out` and `cs_out` are zero.
- R2: Op 0 (relative call) writes `cmd_ip` to address SP-2. The stack pointer then becomes SP-2, IP becomes `cmd_ip`+`cmd_arg`, and CS becomes `cmd_cs`.
- R3: Op 1 (far call) writes `cmd_cs` to SP-2 and then `cmd_ip` to SP-4. The stack pointer then becomes SP-4, IP becomes `cmd_arg`, and CS becomes `cmd_seg`.
- R4: Op 2 (register call) writes `cmd_ip` to SP-2. The stack pointer then becomes SP-2, IP becomes `cmd_arg`, and CS stays `cmd_cs`.
- R5: Op 3 (near return) reads IP from address SP. The stack pointer then becomes SP+2+`cmd_arg`, and CS becomes `cmd_cs`.
- R6: Op 4 (far return) reads IP from SP and then CS from SP+2. The stack pointer then becomes SP+4+`cmd_arg`.
- R7: Op 5 (frame entry) writes BP to SP-2. BP then becomes SP-2 and the stack pointer becomes SP-2-`cmd_arg`. IP and CS take `cmd_ip` and `cmd_cs`.
- R8: Op 6 (frame exit) first sets SP to BP and then reads BP from that address. The stack pointer then becomes the old BP+2. IP and CS take `cmd_ip` and `cmd_cs`.
- R9: While `mem_ready` is low, a pending access keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` unchanged. An access completes only in a cycle where `mem_ready` is high.
- R10: `busy` rises in the cycle after a command is accepted and stays high until the clock edge at which the last access completes. In the next cycle `done` is high for one cycle and all results are valid.
- R11: A command offered while `busy` is high is ignored. It causes no access and changes no result.
- R12: Op 7 is reserved. It is ignored: `busy` stays low, there is no access, and SP, BP, IP and CS keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_op | input | 3 | Command code (0..6, 7 reserved) |
| cmd_ip | input | 16 | Address of the instruction after the current one |
| cmd_cs | input | 16 | Current code segment |
| cmd_arg | input | 16 | Displacement, target offset, byte count or frame size |
| cmd_seg | input | 16 | Target segment of a far call |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when results are valid |
| ip_out | output | 16 | Resulting instruction pointer |
| cs_out | output | 16 | Resulting code segment |
| sp_out | output | 16 | Stack pointer |
| bp_out | output | 16 | Frame base pointer |
| mem_req | output | 1 | Memory access requested |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes at this clock edge |

## Verification
The bench offers a command in one cycle. It expects `busy` to be high when the next sample is taken half a cycle after the accepting edge, and `mem_req` to be up at the same time. Every access completes at the first edge where `mem_ready` is high. `done` and the new SP, BP, IP and CS values appear one cycle after the edge that finishes the final access. The bench therefore samples the results in the cycle where `done` is first seen, at the falling clock edge, and not after a fixed delay. The memory model runs with several wait counts, so the same checks cover accesses that finish at once and accesses that are held back.

// File: rtl/crs_pkg.sv
package crs_pkg;

  typedef enum logic [2:0] {
    OP_CALL_REL   = 3'd0,
    OP_CALL_FAR   = 3'd1,
    OP_CALL_REG   = 3'd2,
    OP_RET_NEAR   = 3'd3,
    OP_RET_FAR    = 3'd4,
    OP_FRAME_OPEN = 3'd5,
    OP_FRAME_DROP = 3'd6,
    OP_RESERVED   = 3'd7
  } crs_op_e;

  typedef enum logic [1:0] {
    DST_IP   = 2'd0,
    DST_CS   = 2'd1,
    DST_BP   = 2'd2,
    DST_NONE = 2'd3
  } crs_dst_e;

  function automatic logic op_legal(input logic [2:0] op);
    return op != OP_RESERVED;
  endfunction

  function automatic logic op_two_words(input crs_op_e op);
    return (op == OP_CALL_FAR) || (op == OP_RET_FAR);
  endfunction

  function automatic logic op_pushes(input crs_op_e op);
    return (op == OP_CALL_REL) || (op == OP_CALL_FAR) ||
           (op == OP_CALL_REG) || (op == OP_FRAME_OPEN);
  endfunction

endpackage

// File: rtl/crs_seq.sv
module crs_seq
  import crs_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  input  logic [2:0]   cmd_op,
  input  logic [W-1:0] cmd_ip,
  input  logic [W-1:0] cmd_cs,
  input  logic [W-1:0] cmd_arg,
  input  logic [W-1:0] cmd_seg,
  input  logic [W-1:0] cur_bp,
  input  logic         mem_ready,
  output logic         busy,
  output logic         done,
  output logic         accept,
  output logic         xfer,
  output logic         last,
  output logic         uop_push,
  output crs_dst_e     uop_dst,
  output logic [W-1:0] uop_wdata,
  output crs_op_e      op_q,
  output logic [W-1:0] ip_q,
  output logic [W-1:0] cs_q,
  output logic [W-1:0] arg_q,
  output logic [W-1:0] seg_q
);

  logic busy_q;
  logic step_q;
  logic done_q;

  assign accept = cmd_valid && !busy_q && op_legal(cmd_op);
  assign xfer   = busy_q && mem_ready;
  assign last   = step_q || !op_two_words(op_q);
  assign busy   = busy_q;
  assign done   = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= 1'b0;
      done_q <= 1'b0;
      op_q   <= OP_CALL_REL;
      ip_q   <= '0;
      cs_q   <= '0;
      arg_q  <= '0;
      seg_q  <= '0;
    end else begin
      done_q <= xfer && last;
      if (accept) begin
        busy_q <= 1'b1;
        step_q <= 1'b0;
        op_q   <= crs_op_e'(cmd_op);
        ip_q   <= cmd_ip;
        cs_q   <= cmd_cs;
        arg_q  <= cmd_arg;
        seg_q  <= cmd_seg;
      end else if (xfer) begin
        if (last) begin
          busy_q <= 1'b0;
          step_q <= 1'b0;
        end else begin
          step_q <= 1'b1;
        end
      end
    end
  end

  // micro-operation for the current step
  always_comb begin
    uop_push  = op_pushes(op_q);
    uop_dst   = DST_NONE;
    uop_wdata = '0;
    case (op_q)
      OP_CALL_REL,
      OP_CALL_REG:   uop_wdata = ip_q;
      OP_CALL_FAR:   uop_wdata = step_q ? ip_q : cs_q;
      OP_RET_NEAR:   uop_dst   = DST_IP;
      OP_RET_FAR:    uop_dst   = step_q ? DST_CS : DST_IP;
      OP_FRAME_OPEN: uop_wdata = cur_bp;
      OP_FRAME_DROP: uop_dst   = DST_BP;
      default:       uop_dst   = DST_NONE;
    endcase
  end

  // R10: the step index never runs past the second word of a far transfer
  assert_step_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && step_q) |-> op_two_words(op_q));

endmodule

// File: rtl/crs_state.sv
module crs_state
  import crs_pkg::*;
#(
  parameter int           W       = 16,
  parameter logic [W-1:0] SP_INIT = 16'h0100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept,
  input  logic [2:0]   cmd_op,
  input  logic         xfer,
  input  logic         last,
  input  logic         uop_push,
  input  crs_dst_e     uop_dst,
  input  crs_op_e      op_q,
  input  logic [W-1:0] ip_q,
  input  logic [W-1:0] cs_q,
  input  logic [W-1:0] arg_q,
  input  logic [W-1:0] seg_q,
  input  logic [W-1:0] rdata,
  output logic [W-1:0] sp,
  output logic [W-1:0] bp,
  output logic [W-1:0] ip_res,
  output logic [W-1:0] cs_res,
  output logic [W-1:0] addr
);

  localparam int BYTES = W / 8;

  function automatic logic [W-1:0] slot_below(input logic [W-1:0] p);
    return p - W'(BYTES);
  endfunction

  function automatic logic [W-1:0] slot_above(input logic [W-1:0] p);
    return p + W'(BYTES);
  endfunction

  logic [W-1:0] sp_step;
  logic [W-1:0] sp_n, bp_n, ip_n, cs_n;

  assign addr    = uop_push ? slot_below(sp) : sp;
  assign sp_step = uop_push ? slot_below(sp) : slot_above(sp);

  always_comb begin
    sp_n = sp;
    bp_n = bp;
    ip_n = ip_res;
    cs_n = cs_res;
    if (accept && (cmd_op == OP_FRAME_DROP)) begin
      sp_n = bp;
    end else if (xfer) begin
      sp_n = sp_step;
      case (uop_dst)
        DST_IP:  ip_n = rdata;
        DST_CS:  cs_n = rdata;
        DST_BP:  bp_n = rdata;
        default: ;
      endcase
      if (last) begin
        case (op_q)
          OP_CALL_REL: begin ip_n = ip_q + arg_q; cs_n = cs_q; end
          OP_CALL_FAR: begin ip_n = arg_q;        cs_n = seg_q; end
          OP_CALL_REG: begin ip_n = arg_q;        cs_n = cs_q; end
          OP_RET_NEAR: begin cs_n = cs_q; sp_n = sp_step + arg_q; end
          OP_RET_FAR:  sp_n = sp_step + arg_q;
          OP_FRAME_OPEN: begin
            bp_n = sp_step;
            sp_n = sp_step - arg_q;
            ip_n = ip_q;
            cs_n = cs_q;
          end
          OP_FRAME_DROP: begin ip_n = ip_q; cs_n = cs_q; end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp     <= SP_INIT;
      bp     <= '0;
      ip_res <= '0;
      cs_res <= '0;
    end else begin
      sp     <= sp_n;
      bp     <= bp_n;
      ip_res <= ip_n;
      cs_res <= cs_n;
    end
  end

  // R8: a frame exit reads from the slot the base pointer named at accept
  assert_drop_reads_bp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_op == OP_FRAME_DROP) |=> (addr == $past(bp)));

endmodule

// File: rtl/callret_seq.sv
module callret_seq
  import crs_pkg::*;
#(
  parameter int           W       = 16,
  parameter logic [W-1:0] SP_INIT = 16'h0100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  input  logic [2:0]   cmd_op,
  input  logic [W-1:0] cmd_ip,
  input  logic [W-1:0] cmd_cs,
  input  logic [W-1:0] cmd_arg,
  input  logic [W-1:0] cmd_seg,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] ip_out,
  output logic [W-1:0] cs_out,
  output logic [W-1:0] sp_out,
  output logic [W-1:0] bp_out,
  output logic         mem_req,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata,
  input  logic         mem_ready
);

  localparam int BYTES = W / 8;

  logic         acc_fire;
  logic         xfer_fire;
  logic         last_fire;
  logic         uop_push;
  crs_dst_e     uop_dst;
  logic [W-1:0] uop_wdata;
  crs_op_e      op_q;
  logic [W-1:0] ip_q, cs_q, arg_q, seg_q;

  crs_seq #(.W(W)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_ip    (cmd_ip),
    .cmd_cs    (cmd_cs),
    .cmd_arg   (cmd_arg),
    .cmd_seg   (cmd_seg),
    .cur_bp    (bp_out),
    .mem_ready (mem_ready),
    .busy      (busy),
    .done      (done),
    .accept    (acc_fire),
    .xfer      (xfer_fire),
    .last      (last_fire),
    .uop_push  (uop_push),
    .uop_dst   (uop_dst),
    .uop_wdata (uop_wdata),
    .op_q      (op_q),
    .ip_q      (ip_q),
    .cs_q      (cs_q),
    .arg_q     (arg_q),
    .seg_q     (seg_q)
  );

  crs_state #(.W(W), .SP_INIT(SP_INIT)) state_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (acc_fire),
    .cmd_op   (cmd_op),
    .xfer     (xfer_fire),
    .last     (last_fire),
    .uop_push (uop_push),
    .uop_dst  (uop_dst),
    .op_q     (op_q),
    .ip_q     (ip_q),
    .cs_q     (cs_q),
    .arg_q    (arg_q),
    .seg_q    (seg_q),
    .rdata    (mem_rdata),
    .sp       (sp_out),
    .bp       (bp_out),
    .ip_res   (ip_out),
    .cs_res   (cs_out),
    .addr     (mem_addr)
  );

  assign mem_req   = busy;
  assign mem_we    = busy && uop_push;
  assign mem_wdata = uop_wdata;

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) &&
                                 $stable(mem_addr) && $stable(mem_wdata)));

  assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(xfer_fire && last_fire)) |=> busy);

  assert_done_after_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_push_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_addr == sp_out - W'(BYTES)));

  assert_pop_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_addr == sp_out));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !acc_fire) |=> ($stable(sp_out) && $stable(bp_out) &&
                              $stable(ip_out) && $stable(cs_out) && !mem_req));

endmodule

// File: tb/callret_seq_tb_top.sv
module callret_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [15:0] cmd_ip, cmd_cs, cmd_arg, cmd_seg;
  logic        busy, done, mem_req, mem_we;
  logic [15:0] ip_out, cs_out, sp_out, bp_out, mem_addr, mem_wdata;
  logic [15:0] mem_rdata;
  logic        mem_ready;

  always #2 clk = ~clk;

  callret_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ip(cmd_ip), .cmd_cs(cmd_cs), .cmd_arg(cmd_arg), .cmd_seg(cmd_seg),
    .busy(busy), .done(done), .ip_out(ip_out), .cs_out(cs_out),
    .sp_out(sp_out), .bp_out(bp_out), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready)
  );

  // word memory with programmable wait count and an access log
  logic [15:0] mem [0:255];
  int          wait_cfg;
  int          cnt;
  logic        rdy_q;
  int          wr_n, rd_n;
  logic [15:0] wr_addr [0:63];
  logic [15:0] wr_data [0:63];
  logic [15:0] rd_addr [0:63];

  assign mem_ready = rdy_q;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] = 16'h0;
      rdy_q = 1'b0; cnt = wait_cfg; wr_n = 0; rd_n = 0; mem_rdata = 16'h0;
    end else if (rdy_q) begin
      rdy_q = 1'b0;
      cnt   = wait_cfg;
    end else if (mem_req) begin
      if (cnt == 0) begin
        rdy_q = 1'b1;
        if (mem_we) begin
          mem[mem_addr[8:1]] = mem_wdata;
          wr_addr[wr_n % 64] = mem_addr;
          wr_data[wr_n % 64] = mem_wdata;
          wr_n++;
        end else begin
          mem_rdata = mem[mem_addr[8:1]];
          rd_addr[rd_n % 64] = mem_addr;
          rd_n++;
        end
      end else begin
        cnt--;
      end
    end
  end

  int tests = 0;
  int fails = 0;
  int wb, rb;
  logic [15:0] exp_sp, exp_bp;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic eq(input string req, input string what,
                    input logic [15:0] act, input logic [15:0] exp);
    chk(act === exp, req, what, act, exp);
  endtask

  task automatic issue(input logic [2:0] op, input logic [15:0] ip,
                       input logic [15:0] cs, input logic [15:0] arg,
                       input logic [15:0] seg);
    @(negedge clk);
    wb = wr_n; rb = rd_n;
    cmd_valid = 1'b1; cmd_op = op; cmd_ip = ip; cmd_cs = cs;
    cmd_arg = arg; cmd_seg = seg;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(input string req);
    eq(req, "busy after accept", {15'd0, busy}, 16'd1);
    for (int i = 0; i < 200; i++) begin
      if (done) return;
      @(negedge clk);
    end
    chk(1'b0, req, "done timeout", 16'd0, 16'd1);
  endtask

  task automatic t_reset;
    eq("R1", "busy", {15'd0, busy}, 16'd0);
    eq("R1", "done", {15'd0, done}, 16'd0);
    eq("R1", "mem_req", {15'd0, mem_req}, 16'd0);
    eq("R1", "sp", sp_out, 16'h0100);
    eq("R1", "bp", bp_out, 16'h0000);
    eq("R1", "ip", ip_out, 16'h0000);
    eq("R1", "cs", cs_out, 16'h0000);
  endtask

  task automatic t_call_rel;
    wait_cfg = 0;
    issue(3'd0, 16'h1234, 16'h2000, 16'h0010, 16'h0);
    wait_done("R2");
    eq("R2", "writes", 16'(wr_n - wb), 16'd1);
    eq("R2", "push addr", wr_addr[wb % 64], 16'h00FE);
    eq("R2", "push data", wr_data[wb % 64], 16'h1234);
    eq("R2", "sp", sp_out, 16'h00FE);
    eq("R2", "ip", ip_out, 16'h1244);
    eq("R2", "cs", cs_out, 16'h2000);
    eq("R10", "done pulse", {15'd0, busy}, 16'd0);
    @(negedge clk);
    eq("R10", "done one cycle", {15'd0, done}, 16'd0);
  endtask

  task automatic t_ret_near(input logic [15:0] imm, input logic [15:0] slot,
                            input logic [15:0] exp_ip);
    issue(3'd3, 16'h5555, 16'h2000, imm, 16'h0);
    wait_done("R5");
    eq("R5", "reads", 16'(rd_n - rb), 16'd1);
    eq("R5", "pop addr", rd_addr[rb % 64], slot);
    eq("R5", "ip", ip_out, exp_ip);
    eq("R5", "cs", cs_out, 16'h2000);
    eq("R5", "sp", sp_out, slot + 16'd2 + imm);
  endtask

  task automatic t_far_call;
    wait_cfg = 2;
    issue(3'd1, 16'h0050, 16'h2000, 16'h4000, 16'h3000);
    wait_done("R3");
    eq("R3", "writes", 16'(wr_n - wb), 16'd2);
    eq("R3", "cs slot", wr_addr[wb % 64], 16'h00FE);
    eq("R3", "cs data", wr_data[wb % 64], 16'h2000);
    eq("R3", "ip slot", wr_addr[(wb + 1) % 64], 16'h00FC);
    eq("R3", "ip data", wr_data[(wb + 1) % 64], 16'h0050);
    eq("R3", "sp", sp_out, 16'h00FC);
    eq("R3", "ip", ip_out, 16'h4000);
    eq("R3", "cs", cs_out, 16'h3000);
  endtask

  task automatic t_far_ret;
    wait_cfg = 1;
    issue(3'd4, 16'h7777, 16'h3000, 16'h0004, 16'h0);
    wait_done("R6");
    eq("R6", "reads", 16'(rd_n - rb), 16'd2);
    eq("R6", "ip slot", rd_addr[rb % 64], 16'h00FC);
    eq("R6", "cs slot", rd_addr[(rb + 1) % 64], 16'h00FE);
    eq("R6", "ip", ip_out, 16'h0050);
    eq("R6", "cs", cs_out, 16'h2000);
    eq("R6", "sp", sp_out, 16'h0104);
  endtask

  task automatic t_reg_call;
    wait_cfg = 0;
    issue(3'd2, 16'h0777, 16'h2000, 16'hBEEF, 16'h1111);
    wait_done("R4");
    eq("R4", "push addr", wr_addr[wb % 64], 16'h0102);
    eq("R4", "push data", wr_data[wb % 64], 16'h0777);
    eq("R4", "sp", sp_out, 16'h0102);
    eq("R4", "ip", ip_out, 16'hBEEF);
    eq("R4", "cs", cs_out, 16'h2000);
  endtask

  task automatic frame_open(input logic [15:0] size);
    exp_sp = sp_out; exp_bp = bp_out;
    issue(3'd5, 16'h0A0A, 16'h2000, size, 16'h0);
    wait_done("R7");
    eq("R7", "push addr", wr_addr[wb % 64], exp_sp - 16'd2);
    eq("R7", "push data", wr_data[wb % 64], exp_bp);
    eq("R7", "bp", bp_out, exp_sp - 16'd2);
    eq("R7", "sp", sp_out, exp_sp - 16'd2 - size);
    eq("R7", "ip", ip_out, 16'h0A0A);
  endtask

  task automatic frame_drop(input logic [15:0] exp_new_bp);
    exp_bp = bp_out;
    issue(3'd6, 16'h0B0B, 16'h2000, 16'h0, 16'h0);
    wait_done("R8");
    eq("R8", "pop addr", rd_addr[rb % 64], exp_bp);
    eq("R8", "bp", bp_out, exp_new_bp);
    eq("R8", "sp", sp_out, exp_bp + 16'd2);
    eq("R8", "ip", ip_out, 16'h0B0B);
  endtask

  task automatic t_frames;
    wait_cfg = 1;
    frame_open(16'd8);
    frame_open(16'd4);
    frame_drop(16'h0100);
    frame_drop(16'h0000);
  endtask

  task automatic t_busy_ignore;
    wait_cfg = 3;
    issue(3'd0, 16'h0400, 16'h2000, 16'h0020, 16'h0);
    cmd_valid = 1'b1; cmd_op = 3'd3; cmd_arg = 16'h0040;
    @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done("R11");
    eq("R11", "accesses", 16'(wr_n - wb + rd_n - rb), 16'd1);
    eq("R11", "ip", ip_out, 16'h0420);
    eq("R11", "sp", sp_out, 16'h0108);
    for (int i = 0; i < 4; i++) @(negedge clk);
    eq("R11", "no queued cmd", {15'd0, busy}, 16'd0);
    eq("R11", "sp after", sp_out, 16'h0108);
  endtask

  task automatic t_reserved;
    issue(3'd7, 16'h9999, 16'h9999, 16'h9999, 16'h9999);
    eq("R12", "busy", {15'd0, busy}, 16'd0);
    eq("R12", "mem_req", {15'd0, mem_req}, 16'd0);
    for (int i = 0; i < 3; i++) @(negedge clk);
    eq("R12", "sp", sp_out, 16'h0108);
    eq("R12", "bp", bp_out, 16'h0000);
    eq("R12", "ip", ip_out, 16'h0420);
    eq("R12", "cs", cs_out, 16'h2000);
  endtask

  initial begin
    #(4 * 200000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd0;
    cmd_ip = '0; cmd_cs = '0; cmd_arg = '0; cmd_seg = '0;
    wait_cfg = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_call_rel;
    t_ret_near(16'h0000, 16'h00FE, 16'h1234);
    t_far_call;
    t_far_ret;
    t_reg_call;
    t_frames;
    wait_cfg = 2;
    t_ret_near(16'h0006, 16'h0102, 16'h0777);
    t_busy_ignore;
    t_reserved;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule